// File: doc/BRIEF.md
# DRAM Command Timing Guard

This block sits beside a DRAM command scheduler and keeps a record of every command that has already gone out on the command bus: activates, reads, writes and precharges, each tagged with a rank and a bank. Each cycle the scheduler also presents a candidate command. The block raises a single flag when that candidate could be issued without breaking any minimum spacing rule between commands. The rules it covers apply within a bank, within a rank, and between ranks that share the data bus.

Every spacing limit comes from a timing input counted in clock cycles. The block derives two of its limits from several inputs. Write-to-precharge is CAS latency + 3 + write recovery, which follows from a burst of 8. Write-to-read on the same rank is CAS latency + 3 + write-to-read recovery. Each limit is held as a saturating down-counter. A counter is loaded when the command that starts the limit issues. The flag depends only on the record of commands from earlier cycles. A command issued in the current cycle takes effect from the next cycle.

Top module: `dram_timing_guard`

## Requirements
- R1: Command codes are ACT=0, RD=1, WR=2, PRE=3. After reset, and before any command has issued, every candidate is legal. A limit of N cycles set by a command issued in cycle k keeps the affected candidate illegal in cycles k+1 to k+N-1, and allows it from cycle k+N onward. A limit of 0 or 1 never blocks.
- R2: After an ACT to a bank, an RD to that bank is blocked for t_rcd_rd_i cycles. A WR to that bank is blocked for t_rcd_wr_i cycles. The two limits are set independently.
- R3: After an ACT to a bank, a PRE to that bank is blocked for t_ras_i cycles.
- R4: An ACT to a bank is blocked for t_rp_i cycles after a PRE to that bank. It is also blocked for t_rc_i cycles after an ACT to that bank.
- R5: After an ACT on a rank, an ACT to any other bank of that rank is blocked for t_rrd_i cycles.
- R6: A fifth ACT on one rank is blocked until t_faw_i cycles after the fourth-most-recent ACT on that rank.
- R7: After a WR to a bank, a PRE to that bank is blocked for t_cl_i + 3 + t_wr_i cycles.
- R8: After a WR on a rank, an RD to any bank of that rank is blocked for t_cl_i + 3 + t_wtr_i cycles.
- R9: On a rank, a PRE is blocked for t_rtp_i cycles after an RD, and for t_ptp_i cycles after another PRE.
- R10: After an RD on a rank, a WR to any bank of that rank is blocked for t_rtw_i cycles.
- R11: When the earlier command went to a different rank, three turnaround gaps apply. A WR followed by an RD waits t_xwr_rd_i cycles. An RD followed by a WR waits t_xrd_wr_i cycles. A WR followed by a WR waits t_xwr_wr_i cycles.
- R12: A command places no limit on a bank or rank outside the scope its rule names. An ACT does not block an ACT on another rank. A WR does not block a PRE to a different bank. An ACT does not block an RD to a different bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | A command issues this cycle |
| issue_cmd_i | input | 2 | Issued command code |
| issue_rank_i | input | 1 | Issued command rank |
| issue_bank_i | input | 3 | Issued command bank |
| prop_cmd_i | input | 2 | Candidate command code |
| prop_rank_i | input | 1 | Candidate rank |
| prop_bank_i | input | 3 | Candidate bank |
| t_cl_i | input | 6 | CAS latency |
| t_rcd_rd_i | input | 6 | ACT to RD, same bank |
| t_rcd_wr_i | input | 6 | ACT to WR, same bank |
| t_ras_i | input | 6 | ACT to PRE, same bank |
| t_rp_i | input | 6 | PRE to ACT, same bank |
| t_rc_i | input | 6 | ACT to ACT, same bank |
| t_rrd_i | input | 6 | ACT to ACT, same rank |
| t_faw_i | input | 6 | Four-activate window length |
| t_wr_i | input | 6 | Write recovery |
| t_wtr_i | input | 6 | Write-to-read recovery |
| t_rtp_i | input | 6 | RD to PRE, same rank |
| t_rtw_i | input | 6 | RD to WR, same rank |
| t_ptp_i | input | 6 | PRE to PRE, same rank |
| t_xwr_rd_i | input | 6 | WR to RD, other rank |
| t_xrd_wr_i | input | 6 | RD to WR, other rank |
| t_xwr_wr_i | input | 6 | WR to WR, other rank |
| legal_o | output | 1 | Candidate may issue now |

## Verification
Each rule is probed in pairs, one cycle before and exactly at its limit. An off-by-one in the counter load or in the point where the flag is sampled would pass one probe of the pair and fail the other. The composite write limits are probed at their derived boundaries of 14 and 11 cycles. A design that left out the CAS or burst terms would report the command legal several cycles too early. The four-activate window is exercised with activates spaced wider than t_rrd_i. The check then shows whether the fifth activate waits on the oldest one, rather than on the most recent one or on a fixed count. Cross-rank probes and other-bank probes show whether a limit reaches too far, for example whether a write on one rank wrongly blocks an activate on another rank.

// File: rtl/dram_timing_pkg.sv
package dram_timing_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  localparam int unsigned ACT_WINDOW = 4;
endpackage

// File: rtl/dram_gap_counter.sv
module dram_gap_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q, dec;

  assign dec = (cnt_q == '0) ? '0 : cnt_q - CW'(1);

  // keep the longer of the running and the new limit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i && val_i > dec) cnt_q <= val_i;
    else                           cnt_q <= dec;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/dram_bank_gaps.sv
module dram_bank_gaps #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          wr_i,
  input  logic          pre_i,
  input  logic [CW-1:0] ld_rcd_rd_i,
  input  logic [CW-1:0] ld_rcd_wr_i,
  input  logic [CW-1:0] ld_ras_i,
  input  logic [CW-1:0] ld_rp_i,
  input  logic [CW-1:0] ld_rc_i,
  input  logic [CW-1:0] ld_wr2pre_i,
  output logic          act_ok_o,
  output logic          rd_ok_o,
  output logic          wr_ok_o,
  output logic          pre_ok_o
);
  dram_gap_counter #(.CW(CW)) u_act (
    .clk_i, .rst_ni, .load_i(act_i | pre_i),
    .val_i(act_i ? ld_rc_i : ld_rp_i), .zero_o(act_ok_o)
  );

  dram_gap_counter #(.CW(CW)) u_rd (
    .clk_i, .rst_ni, .load_i(act_i), .val_i(ld_rcd_rd_i), .zero_o(rd_ok_o)
  );

  dram_gap_counter #(.CW(CW)) u_wr (
    .clk_i, .rst_ni, .load_i(act_i), .val_i(ld_rcd_wr_i), .zero_o(wr_ok_o)
  );

  dram_gap_counter #(.CW(CW)) u_pre (
    .clk_i, .rst_ni, .load_i(act_i | wr_i),
    .val_i(act_i ? ld_ras_i : ld_wr2pre_i), .zero_o(pre_ok_o)
  );
endmodule

// File: rtl/dram_rank_gaps.sv
module dram_rank_gaps
  import dram_timing_pkg::*;
#(
  parameter int unsigned CW     = 8,
  parameter int unsigned N_BANK = 8,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              other_i,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  cmd_e              prop_cmd_i,
  input  logic [BANK_W-1:0] prop_bank_i,
  input  logic [CW-1:0]     ld_rcd_rd_i,
  input  logic [CW-1:0]     ld_rcd_wr_i,
  input  logic [CW-1:0]     ld_ras_i,
  input  logic [CW-1:0]     ld_rp_i,
  input  logic [CW-1:0]     ld_rc_i,
  input  logic [CW-1:0]     ld_wr2pre_i,
  input  logic [CW-1:0]     ld_rrd_i,
  input  logic [CW-1:0]     ld_faw_i,
  input  logic [CW-1:0]     ld_wr2rd_i,
  input  logic [CW-1:0]     ld_rtp_i,
  input  logic [CW-1:0]     ld_rtw_i,
  input  logic [CW-1:0]     ld_ptp_i,
  input  logic [CW-1:0]     ld_xwr_rd_i,
  input  logic [CW-1:0]     ld_xrd_wr_i,
  input  logic [CW-1:0]     ld_xwr_wr_i,
  output logic              ok_o
);
  localparam int unsigned PW = $clog2(ACT_WINDOW);

  logic is_act, is_rd, is_wr, is_pre, o_rd, o_wr;
  assign is_act = hit_i && cmd_i == CMD_ACT;
  assign is_rd  = hit_i && cmd_i == CMD_RD;
  assign is_wr  = hit_i && cmd_i == CMD_WR;
  assign is_pre = hit_i && cmd_i == CMD_PRE;
  assign o_rd   = other_i && cmd_i == CMD_RD;
  assign o_wr   = other_i && cmd_i == CMD_WR;

  logic [N_BANK-1:0] act_ok, rd_ok, wr_ok, pre_ok;

  for (genvar b = 0; b < N_BANK; b++) begin : g_bank
    logic sel;
    assign sel = bank_i == BANK_W'(b);
    dram_bank_gaps #(.CW(CW)) u_bank (
      .clk_i, .rst_ni,
      .act_i(is_act && sel), .wr_i(is_wr && sel), .pre_i(is_pre && sel),
      .ld_rcd_rd_i, .ld_rcd_wr_i, .ld_ras_i, .ld_rp_i, .ld_rc_i, .ld_wr2pre_i,
      .act_ok_o(act_ok[b]), .rd_ok_o(rd_ok[b]),
      .wr_ok_o(wr_ok[b]), .pre_ok_o(pre_ok[b])
    );
  end

  logic rrd_ok, wtr_ok, rtp_ok, rtw_ok, ptp_ok, xrd_ok, xwr_ok;

  dram_gap_counter #(.CW(CW)) u_rrd (
    .clk_i, .rst_ni, .load_i(is_act), .val_i(ld_rrd_i), .zero_o(rrd_ok));
  dram_gap_counter #(.CW(CW)) u_wtr (
    .clk_i, .rst_ni, .load_i(is_wr), .val_i(ld_wr2rd_i), .zero_o(wtr_ok));
  dram_gap_counter #(.CW(CW)) u_rtp (
    .clk_i, .rst_ni, .load_i(is_rd), .val_i(ld_rtp_i), .zero_o(rtp_ok));
  dram_gap_counter #(.CW(CW)) u_rtw (
    .clk_i, .rst_ni, .load_i(is_rd), .val_i(ld_rtw_i), .zero_o(rtw_ok));
  dram_gap_counter #(.CW(CW)) u_ptp (
    .clk_i, .rst_ni, .load_i(is_pre), .val_i(ld_ptp_i), .zero_o(ptp_ok));
  dram_gap_counter #(.CW(CW)) u_xrd (
    .clk_i, .rst_ni, .load_i(o_wr), .val_i(ld_xwr_rd_i), .zero_o(xrd_ok));
  dram_gap_counter #(.CW(CW)) u_xwr (
    .clk_i, .rst_ni, .load_i(o_wr | o_rd),
    .val_i(o_wr ? ld_xwr_wr_i : ld_xrd_wr_i), .zero_o(xwr_ok));

  // one slot per activate of the window; slot at ptr holds the oldest one
  logic [PW-1:0] ptr_q;
  logic [ACT_WINDOW-1:0] faw_ok;

  for (genvar s = 0; s < ACT_WINDOW; s++) begin : g_faw
    dram_gap_counter #(.CW(CW)) u_slot (
      .clk_i, .rst_ni, .load_i(is_act && ptr_q == PW'(s)),
      .val_i(ld_faw_i), .zero_o(faw_ok[s]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (is_act) ptr_q <= (ptr_q == PW'(ACT_WINDOW-1)) ? '0 : ptr_q + PW'(1);
  end

  always_comb begin
    unique case (prop_cmd_i)
      CMD_ACT: ok_o = act_ok[prop_bank_i] && rrd_ok && faw_ok[ptr_q];
      CMD_RD:  ok_o = rd_ok[prop_bank_i] && wtr_ok && xrd_ok;
      CMD_WR:  ok_o = wr_ok[prop_bank_i] && rtw_ok && xwr_ok;
      default: ok_o = pre_ok[prop_bank_i] && rtp_ok && ptp_ok;
    endcase
  end
endmodule

// File: rtl/dram_timing_guard.sv
module dram_timing_guard
  import dram_timing_pkg::*;
#(
  parameter int unsigned N_RANK    = 2,
  parameter int unsigned N_BANK    = 8,
  parameter int unsigned TIME_W    = 6,
  parameter int unsigned BURST_LEN = 8,
  localparam int unsigned RANK_W   = (N_RANK > 1) ? $clog2(N_RANK) : 1,
  localparam int unsigned BANK_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_cmd_i,
  input  logic [RANK_W-1:0] issue_rank_i,
  input  logic [BANK_W-1:0] issue_bank_i,
  input  logic [1:0]        prop_cmd_i,
  input  logic [RANK_W-1:0] prop_rank_i,
  input  logic [BANK_W-1:0] prop_bank_i,
  input  logic [TIME_W-1:0] t_cl_i,
  input  logic [TIME_W-1:0] t_rcd_rd_i,
  input  logic [TIME_W-1:0] t_rcd_wr_i,
  input  logic [TIME_W-1:0] t_ras_i,
  input  logic [TIME_W-1:0] t_rp_i,
  input  logic [TIME_W-1:0] t_rc_i,
  input  logic [TIME_W-1:0] t_rrd_i,
  input  logic [TIME_W-1:0] t_faw_i,
  input  logic [TIME_W-1:0] t_wr_i,
  input  logic [TIME_W-1:0] t_wtr_i,
  input  logic [TIME_W-1:0] t_rtp_i,
  input  logic [TIME_W-1:0] t_rtw_i,
  input  logic [TIME_W-1:0] t_ptp_i,
  input  logic [TIME_W-1:0] t_xwr_rd_i,
  input  logic [TIME_W-1:0] t_xrd_wr_i,
  input  logic [TIME_W-1:0] t_xwr_wr_i,
  output logic              legal_o
);
  // room for cl + burst/2 - 1 + recovery
  localparam int unsigned CW = TIME_W + 2;

  function automatic logic [CW-1:0] to_load(input logic [CW-1:0] n);
    return (n == '0) ? '0 : n - CW'(1);
  endfunction

  logic [CW-1:0] wr2pre, wr2rd;
  assign wr2pre = CW'(t_cl_i) + CW'(BURST_LEN / 2) - CW'(1) + CW'(t_wr_i);
  assign wr2rd  = CW'(t_cl_i) + CW'(BURST_LEN / 2) - CW'(1) + CW'(t_wtr_i);

  logic [CW-1:0] ld_rcd_rd, ld_rcd_wr, ld_ras, ld_rp, ld_rc, ld_wr2pre, ld_rrd,
                 ld_faw, ld_wr2rd, ld_rtp, ld_rtw, ld_ptp, ld_xwr_rd, ld_xrd_wr,
                 ld_xwr_wr;
  assign ld_rcd_rd = to_load(CW'(t_rcd_rd_i));
  assign ld_rcd_wr = to_load(CW'(t_rcd_wr_i));
  assign ld_ras    = to_load(CW'(t_ras_i));
  assign ld_rp     = to_load(CW'(t_rp_i));
  assign ld_rc     = to_load(CW'(t_rc_i));
  assign ld_wr2pre = to_load(wr2pre);
  assign ld_rrd    = to_load(CW'(t_rrd_i));
  assign ld_faw    = to_load(CW'(t_faw_i));
  assign ld_wr2rd  = to_load(wr2rd);
  assign ld_rtp    = to_load(CW'(t_rtp_i));
  assign ld_rtw    = to_load(CW'(t_rtw_i));
  assign ld_ptp    = to_load(CW'(t_ptp_i));
  assign ld_xwr_rd = to_load(CW'(t_xwr_rd_i));
  assign ld_xrd_wr = to_load(CW'(t_xrd_wr_i));
  assign ld_xwr_wr = to_load(CW'(t_xwr_wr_i));

  cmd_e issue_cmd, prop_cmd;
  assign issue_cmd = cmd_e'(issue_cmd_i);
  assign prop_cmd  = cmd_e'(prop_cmd_i);

  logic [N_RANK-1:0] rank_ok;

  for (genvar r = 0; r < N_RANK; r++) begin : g_rank
    logic own;
    assign own = issue_rank_i == RANK_W'(r);
    dram_rank_gaps #(.CW(CW), .N_BANK(N_BANK), .BANK_W(BANK_W)) u_rank (
      .clk_i, .rst_ni,
      .hit_i(issue_valid_i && own), .other_i(issue_valid_i && !own),
      .cmd_i(issue_cmd), .bank_i(issue_bank_i),
      .prop_cmd_i(prop_cmd), .prop_bank_i(prop_bank_i),
      .ld_rcd_rd_i(ld_rcd_rd), .ld_rcd_wr_i(ld_rcd_wr), .ld_ras_i(ld_ras),
      .ld_rp_i(ld_rp), .ld_rc_i(ld_rc), .ld_wr2pre_i(ld_wr2pre),
      .ld_rrd_i(ld_rrd), .ld_faw_i(ld_faw), .ld_wr2rd_i(ld_wr2rd),
      .ld_rtp_i(ld_rtp), .ld_rtw_i(ld_rtw), .ld_ptp_i(ld_ptp),
      .ld_xwr_rd_i(ld_xwr_rd), .ld_xrd_wr_i(ld_xrd_wr), .ld_xwr_wr_i(ld_xwr_wr),
      .ok_o(rank_ok[r])
    );
  end

  assign legal_o = rank_ok[prop_rank_i];
endmodule

// File: rtl/dram_timing_guard_chk.sv
module dram_timing_guard_chk #(
  parameter int unsigned RANK_W = 1,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned TIME_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_valid_i,
  input logic [1:0]        issue_cmd_i,
  input logic [RANK_W-1:0] issue_rank_i,
  input logic [BANK_W-1:0] issue_bank_i,
  input logic [1:0]        prop_cmd_i,
  input logic [RANK_W-1:0] prop_rank_i,
  input logic [BANK_W-1:0] prop_bank_i,
  input logic [TIME_W-1:0] t_rcd_rd_i,
  input logic [TIME_W-1:0] t_ras_i,
  input logic [TIME_W-1:0] t_rc_i,
  input logic [TIME_W-1:0] t_xwr_rd_i,
  input logic              legal_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            seen_q <= 1'b0;
    else if (issue_valid_i) seen_q <= 1'b1;
  end

  // R1
  idle_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> legal_o);

  // R2
  rcd_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd0 && t_rcd_rd_i >= 2) |=>
    !(prop_cmd_i == 2'd1 && prop_rank_i == $past(issue_rank_i) &&
      prop_bank_i == $past(issue_bank_i) && legal_o));

  // R3
  ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd0 && t_ras_i >= 2) |=>
    !(prop_cmd_i == 2'd3 && prop_rank_i == $past(issue_rank_i) &&
      prop_bank_i == $past(issue_bank_i) && legal_o));

  // R4
  rc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd0 && t_rc_i >= 2) |=>
    !(prop_cmd_i == 2'd0 && prop_rank_i == $past(issue_rank_i) &&
      prop_bank_i == $past(issue_bank_i) && legal_o));

  // R7
  wr2pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd2) |=>
    !(prop_cmd_i == 2'd3 && prop_rank_i == $past(issue_rank_i) &&
      prop_bank_i == $past(issue_bank_i) && legal_o));

  // R8
  wr2rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd2) |=>
    !(prop_cmd_i == 2'd1 && prop_rank_i == $past(issue_rank_i) && legal_o));

  // R11
  xrank_wr_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_i && issue_cmd_i == 2'd2 && t_xwr_rd_i >= 2) |=>
    !(prop_cmd_i == 2'd1 && prop_rank_i != $past(issue_rank_i) && legal_o));
endmodule

bind dram_timing_guard dram_timing_guard_chk #(
  .RANK_W(RANK_W), .BANK_W(BANK_W), .TIME_W(TIME_W)
) chk_i (
  .clk_i, .rst_ni, .issue_valid_i, .issue_cmd_i, .issue_rank_i, .issue_bank_i,
  .prop_cmd_i, .prop_rank_i, .prop_bank_i, .t_rcd_rd_i, .t_ras_i, .t_rc_i,
  .t_xwr_rd_i, .legal_o
);

// File: tb/dram_timing_guard_tb.sv
`timescale 1ns/1ps
module dram_timing_guard_tb_top;
  localparam logic [1:0] ACT = 2'd0, RD = 2'd1, WR = 2'd2, PRE = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic issue_valid_i = 1'b0;
  logic [1:0] issue_cmd_i = '0, prop_cmd_i = '0;
  logic issue_rank_i = 1'b0, prop_rank_i = 1'b0;
  logic [2:0] issue_bank_i = '0, prop_bank_i = '0;
  logic legal_o;

  // composite: wr->pre = 5+3+6 = 14, wr->rd = 5+3+3 = 11
  logic [5:0] t_cl = 6'd5, t_rcd_rd = 6'd4, t_rcd_wr = 6'd3, t_ras = 6'd12,
              t_rp = 6'd4, t_rc = 6'd16, t_rrd = 6'd3, t_faw = 6'd20,
              t_wr = 6'd6, t_wtr = 6'd3, t_rtp = 6'd3, t_rtw = 6'd5,
              t_ptp = 6'd2, t_xwr_rd = 6'd3, t_xrd_wr = 6'd4, t_xwr_wr = 6'd2;

  always #2.5 clk = ~clk;

  dram_timing_guard dut_i (
    .clk_i(clk), .rst_ni, .issue_valid_i, .issue_cmd_i, .issue_rank_i,
    .issue_bank_i, .prop_cmd_i, .prop_rank_i, .prop_bank_i,
    .t_cl_i(t_cl), .t_rcd_rd_i(t_rcd_rd), .t_rcd_wr_i(t_rcd_wr),
    .t_ras_i(t_ras), .t_rp_i(t_rp), .t_rc_i(t_rc), .t_rrd_i(t_rrd),
    .t_faw_i(t_faw), .t_wr_i(t_wr), .t_wtr_i(t_wtr), .t_rtp_i(t_rtp),
    .t_rtw_i(t_rtw), .t_ptp_i(t_ptp), .t_xwr_rd_i(t_xwr_rd),
    .t_xrd_wr_i(t_xrd_wr), .t_xwr_wr_i(t_xwr_wr), .legal_o
  );

  typedef struct packed {
    logic [1:0] ic; logic ir; logic [2:0] ib;
    logic [5:0] d;
    logic [1:0] pc; logic pr; logic [2:0] pb;
    logic exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{ACT, 1'b0, 3'd1, 6'd3,  RD,  1'b0, 3'd1, 1'b0, 4'd2},  // R2
    '{ACT, 1'b0, 3'd1, 6'd4,  RD,  1'b0, 3'd1, 1'b1, 4'd2},  // R2
    '{ACT, 1'b0, 3'd1, 6'd2,  WR,  1'b0, 3'd1, 1'b0, 4'd2},  // R2
    '{ACT, 1'b0, 3'd1, 6'd3,  WR,  1'b0, 3'd1, 1'b1, 4'd2},  // R2
    '{ACT, 1'b0, 3'd2, 6'd11, PRE, 1'b0, 3'd2, 1'b0, 4'd3},  // R3
    '{ACT, 1'b0, 3'd2, 6'd12, PRE, 1'b0, 3'd2, 1'b1, 4'd3},  // R3
    '{PRE, 1'b1, 3'd3, 6'd3,  ACT, 1'b1, 3'd3, 1'b0, 4'd4},  // R4
    '{PRE, 1'b1, 3'd3, 6'd4,  ACT, 1'b1, 3'd3, 1'b1, 4'd4},  // R4
    '{ACT, 1'b1, 3'd3, 6'd15, ACT, 1'b1, 3'd3, 1'b0, 4'd4},  // R4
    '{ACT, 1'b1, 3'd3, 6'd16, ACT, 1'b1, 3'd3, 1'b1, 4'd4},  // R4
    '{ACT, 1'b0, 3'd0, 6'd2,  ACT, 1'b0, 3'd5, 1'b0, 4'd5},  // R5
    '{ACT, 1'b0, 3'd0, 6'd3,  ACT, 1'b0, 3'd5, 1'b1, 4'd5},  // R5
    '{WR,  1'b0, 3'd4, 6'd13, PRE, 1'b0, 3'd4, 1'b0, 4'd7},  // R7
    '{WR,  1'b0, 3'd4, 6'd14, PRE, 1'b0, 3'd4, 1'b1, 4'd7},  // R7
    '{WR,  1'b0, 3'd4, 6'd10, RD,  1'b0, 3'd6, 1'b0, 4'd8},  // R8
    '{WR,  1'b0, 3'd4, 6'd11, RD,  1'b0, 3'd6, 1'b1, 4'd8},  // R8
    '{RD,  1'b1, 3'd0, 6'd2,  PRE, 1'b1, 3'd7, 1'b0, 4'd9},  // R9
    '{RD,  1'b1, 3'd0, 6'd3,  PRE, 1'b1, 3'd7, 1'b1, 4'd9},  // R9
    '{PRE, 1'b1, 3'd0, 6'd1,  PRE, 1'b1, 3'd2, 1'b0, 4'd9},  // R9
    '{PRE, 1'b1, 3'd0, 6'd2,  PRE, 1'b1, 3'd2, 1'b1, 4'd9},  // R9
    '{RD,  1'b0, 3'd0, 6'd4,  WR,  1'b0, 3'd1, 1'b0, 4'd10}, // R10
    '{RD,  1'b0, 3'd0, 6'd5,  WR,  1'b0, 3'd1, 1'b1, 4'd10}, // R10
    '{WR,  1'b0, 3'd0, 6'd2,  RD,  1'b1, 3'd0, 1'b0, 4'd11}, // R11
    '{WR,  1'b0, 3'd0, 6'd3,  RD,  1'b1, 3'd0, 1'b1, 4'd11}, // R11
    '{RD,  1'b0, 3'd0, 6'd3,  WR,  1'b1, 3'd0, 1'b0, 4'd11}, // R11
    '{RD,  1'b0, 3'd0, 6'd4,  WR,  1'b1, 3'd0, 1'b1, 4'd11}, // R11
    '{WR,  1'b0, 3'd0, 6'd1,  WR,  1'b1, 3'd0, 1'b0, 4'd11}, // R11
    '{WR,  1'b0, 3'd0, 6'd2,  WR,  1'b1, 3'd0, 1'b1, 4'd11}, // R11
    '{ACT, 1'b0, 3'd0, 6'd1,  ACT, 1'b1, 3'd0, 1'b1, 4'd12}, // R12
    '{WR,  1'b0, 3'd4, 6'd1,  PRE, 1'b0, 3'd5, 1'b1, 4'd12}, // R12
    '{ACT, 1'b0, 3'd0, 6'd1,  RD,  1'b0, 3'd1, 1'b1, 4'd12}  // R12
  };

  int n_chk = 0, n_fail = 0;

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s legal=%0b expected=%0b", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    issue_valid_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] c, input logic r, input logic [2:0] b);
    issue_valid_i = 1'b1; issue_cmd_i = c; issue_rank_i = r; issue_bank_i = b;
    @(negedge clk);
    issue_valid_i = 1'b0;
  endtask

  task automatic propose(input logic [1:0] c, input logic r, input logic [2:0] b);
    prop_cmd_i = c; prop_rank_i = r; prop_bank_i = b;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state, every kind of candidate legal
    propose(ACT, 1'b0, 3'd0); #1 check(legal_o, 1'b1, "R1 act");
    propose(RD,  1'b1, 3'd7); #1 check(legal_o, 1'b1, "R1 rd");
    propose(WR,  1'b0, 3'd3); #1 check(legal_o, 1'b1, "R1 wr");
    propose(PRE, 1'b1, 3'd5); #1 check(legal_o, 1'b1, "R1 pre");

    for (int i = 0; i < NV; i++) begin
      do_reset();
      issue(VECS[i].ic, VECS[i].ir, VECS[i].ib);
      propose(VECS[i].pc, VECS[i].pr, VECS[i].pb);
      repeat (int'(VECS[i].d) - 1) @(negedge clk);
      #1 check(legal_o, VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R1: reset clears a pending limit
    do_reset();
    issue(ACT, 1'b0, 3'd0);
    do_reset();
    propose(RD, 1'b0, 3'd0); #1 check(legal_o, 1'b1, "R1 reset clears");

    // R6: ACTs at cycles 0,3,6,9 on rank 0; fifth waits for cycle 20
    do_reset();
    for (int a = 0; a < 4; a++) begin
      issue(ACT, 1'b0, 3'(a));
      if (a < 3) repeat (2) @(negedge clk);
    end
    // now at cycle 10
    propose(ACT, 1'b0, 3'd4);
    repeat (2) @(negedge clk);
    #1 check(legal_o, 1'b0, "R6 window at 12");
    propose(ACT, 1'b1, 3'd4);
    #1 check(legal_o, 1'b1, "R6 other rank free");
    propose(ACT, 1'b0, 3'd4);
    repeat (7) @(negedge clk);
    #1 check(legal_o, 1'b0, "R6 window at 19");
    @(negedge clk);
    #1 check(legal_o, 1'b1, "R6 window at 20");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule